// File: doc/BRIEF.md
# UART Byte Data Path

This block is the byte path between a processor register bus and the shift registers of a UART. A single bus offset serves two data registers. A read at that offset returns the oldest received character. A write at that offset hands a byte to the transmitter. The offset reaches these registers only while the divisor-access input is low. While that input is high, the block forwards the access to the divisor latch through strobe outputs.

Each direction can run with one holding slot or with a FIFO, as the FIFO-enable input selects. The block produces two status flags: data-ready and transmit-data-request. It also keeps the sticky receive error flags, which a line-status read clears. The receiver and the transmitter shift registers lie outside the block. The receiver is modelled as a strobe carrying a character and its error bits. The transmitter is modelled as a shift-register-empty input, answered with a load pulse.

Top module: `uart_dbuf`

## Requirements
- R1: A received character is stored right-justified, with the unused upper bits forced to zero. The char_len_i encoding is 0 = 5 bits, 1 = 6 bits, 2 = 7 bits and 3 = 8 bits. rdata_o[31:8] always reads 0.
- R2: In non-FIFO mode, a read with sel_i=1, rd_i=1 and dlab_i=0 shows the stored byte on rdata_o in the same cycle. The clock edge at the end of that cycle empties the slot, and dr_o reads 0 in the following cycle.
- R3: A data read never changes overrun_o, perr_o, ferr_o or brk_o. These flags are set by a received character that carries the matching error bit, and only lsr_rd_i clears them.
- R4: In FIFO mode, reads return the received characters oldest first, and each read pops one entry. dr_o stays 1 while any entry remains and drops to 0 after the last pop.
- R5: A character that arrives while the receive store is full sets overrun_o and leaves the stored data unchanged. The store is full at 1 entry in non-FIFO mode and at RX_DEPTH entries in FIFO mode. The exception is a read in the same cycle, which makes room for the character.
- R6: In non-FIFO mode, a write fills the holding slot and tdrq_o becomes 0. A write while the slot is full is dropped. In a cycle with tsr_empty_i=1 and a byte held, tsr_load_o is 1 and tsr_data_o carries that byte. tdrq_o returns to 1 in the next cycle.
- R7: In FIFO mode, writes queue up to TX_DEPTH bytes. Each cycle with tsr_empty_i=1 hands out the oldest byte. tdrq_o is 1 exactly when the queue is empty.
- R8: wdata_i[31:8] is ignored, and only wdata_i[7:0] is transmitted.
- R9: With dlab_i=1, accesses at the offset touch neither data register. A read drives div_rd_o=1 and rdata_o=0, and a write drives div_wr_o=1.
- R10: A pulse on fifo_cfg_wr_i flushes both stores. In the next cycle dr_o is 0 and tdrq_o is 1.
- R11: After reset, dr_o is 0, tdrq_o is 1 and all error flags are 0. A data read while the store is empty returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus access to the shared data offset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| dlab_i | input | 1 | Divisor-access bit |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| div_rd_o | output | 1 | Read forwarded to the divisor latch |
| div_wr_o | output | 1 | Write forwarded to the divisor latch |
| fifo_en_i | input | 1 | FIFO mode select |
| fifo_cfg_wr_i | input | 1 | Write of the FIFO-enable control bit (flush) |
| char_len_i | input | 2 | Character length code |
| lsr_rd_i | input | 1 | Line-status read, clears the error flags |
| rx_valid_i | input | 1 | Received-character strobe |
| rx_char_i | input | 8 | Received character |
| rx_perr_i | input | 1 | Parity error of the character |
| rx_ferr_i | input | 1 | Framing error of the character |
| rx_brk_i | input | 1 | Break indication of the character |
| tsr_empty_i | input | 1 | Transmit shift register empty |
| tsr_load_o | output | 1 | Load pulse to the shift register |
| tsr_data_o | output | 8 | Byte for the shift register |
| dr_o | output | 1 | Data-ready flag |
| tdrq_o | output | 1 | Transmit-data-request flag |
| overrun_o | output | 1 | Sticky overrun flag |
| perr_o | output | 1 | Sticky parity error flag |
| ferr_o | output | 1 | Sticky framing error flag |
| brk_o | output | 1 | Sticky break flag |

## Verification
The assertions rely on three assumptions about the inputs:
- fifo_en_i changes only in a cycle where fifo_cfg_wr_i pulses. A mode switch therefore always starts from empty stores, and a store never holds more than its current capacity.
- The shift register is not asserted empty in the same cycle as a flush.
- Read and write strobes at the offset are not raised together.

The bench drives every mode change through one task, which raises both signals in the same cycle. It also pulses tsr_empty_i and the bus strobes in separate cycles, so every stimulus stays inside these assumptions.

// File: rtl/uart_dbuf_pkg.sv
package uart_dbuf_pkg;
  typedef enum logic [1:0] {
    LEN_5 = 2'd0,
    LEN_6 = 2'd1,
    LEN_7 = 2'd2,
    LEN_8 = 2'd3
  } char_len_e;

  function automatic logic [7:0] char_mask(input logic [1:0] len);
    logic [7:0] m;
    case (char_len_e'(len))
      LEN_5:   m = 8'h1f;
      LEN_6:   m = 8'h3f;
      LEN_7:   m = 8'h7f;
      default: m = 8'hff;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/uart_dbuf_fifo.sv
module uart_dbuf_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              cap_one_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q, cap;
  logic              do_push, do_pop;

  assign cap     = cap_one_i ? CNT_W'(1) : CNT_W'(DEPTH);
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q >= cap);
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full_o | do_pop);
  assign data_o  = empty_o ? '0 : mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= data_i;
  end

  // push into a full store without a pop must not change occupancy
  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (cnt_q == $past(cnt_q)));
  assert_cap_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/uart_dbuf_rx.sv
module uart_dbuf_rx
  import uart_dbuf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fifo_en_i,
  input  logic       flush_i,
  input  logic [1:0] char_len_i,
  input  logic       pop_i,
  input  logic       lsr_rd_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_char_i,
  input  logic       rx_perr_i,
  input  logic       rx_ferr_i,
  input  logic       rx_brk_i,
  output logic [7:0] data_o,
  output logic       dr_o,
  output logic       overrun_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       brk_o
);
  logic       empty, full, drop;
  logic [3:0] err_q, err_set;

  uart_dbuf_fifo #(.DATA_W(8), .DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .cap_one_i (~fifo_en_i),
    .push_i    (rx_valid_i),
    .data_i    (rx_char_i & char_mask(char_len_i)),
    .pop_i     (pop_i),
    .data_o    (data_o),
    .empty_o   (empty),
    .full_o    (full)
  );

  assign dr_o    = ~empty;
  assign drop    = rx_valid_i & full & ~pop_i;
  assign err_set = {drop, rx_valid_i & rx_perr_i, rx_valid_i & rx_ferr_i, rx_valid_i & rx_brk_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= (lsr_rd_i ? 4'b0 : err_q) | err_set;
  end

  assign {overrun_o, perr_o, ferr_o, brk_o} = err_q;

  assert_err_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lsr_rd_i && !rx_valid_i) |=> $stable({overrun_o, perr_o, ferr_o, brk_o}));
  assert_dr_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && pop_i && dr_o && !rx_valid_i) |=> !dr_o);
  assert_flush_rx_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !dr_o);
endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx #(
  parameter int DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fifo_en_i,
  input  logic       flush_i,
  input  logic       push_i,
  input  logic [7:0] wdata_i,
  input  logic       tsr_empty_i,
  output logic       tsr_load_o,
  output logic [7:0] tsr_data_o,
  output logic       tdrq_o
);
  logic empty, full;

  uart_dbuf_fifo #(.DATA_W(8), .DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .cap_one_i (~fifo_en_i),
    .push_i    (push_i),
    .data_i    (wdata_i),
    .pop_i     (tsr_load_o),
    .data_o    (tsr_data_o),
    .empty_o   (empty),
    .full_o    (full)
  );

  assign tsr_load_o = tsr_empty_i & ~empty & ~flush_i;
  assign tdrq_o     = empty;

  assert_tdrq_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && tdrq_o && !tsr_empty_i && !flush_i) |=> !tdrq_o);
  assert_flush_tx_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> tdrq_o);
endmodule

// File: rtl/uart_dbuf.sv
module uart_dbuf #(
  parameter int BUS_W    = 32,
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             dlab_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             div_rd_o,
  output logic             div_wr_o,
  input  logic             fifo_en_i,
  input  logic             fifo_cfg_wr_i,
  input  logic [1:0]       char_len_i,
  input  logic             lsr_rd_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_char_i,
  input  logic             rx_perr_i,
  input  logic             rx_ferr_i,
  input  logic             rx_brk_i,
  input  logic             tsr_empty_i,
  output logic             tsr_load_o,
  output logic [7:0]       tsr_data_o,
  output logic             dr_o,
  output logic             tdrq_o,
  output logic             overrun_o,
  output logic             perr_o,
  output logic             ferr_o,
  output logic             brk_o
);
  localparam int PAD_W = BUS_W - 8;

  logic       data_rd, data_wr;
  logic [7:0] rx_byte;

  assign data_rd  = sel_i & rd_i & ~dlab_i;
  assign data_wr  = sel_i & wr_i & ~dlab_i;
  assign div_rd_o = sel_i & rd_i & dlab_i;
  assign div_wr_o = sel_i & wr_i & dlab_i;
  assign rdata_o  = data_rd ? {{PAD_W{1'b0}}, rx_byte} : '0;

  uart_dbuf_rx #(.DEPTH(RX_DEPTH)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_en_i  (fifo_en_i),
    .flush_i    (fifo_cfg_wr_i),
    .char_len_i (char_len_i),
    .pop_i      (data_rd),
    .lsr_rd_i   (lsr_rd_i),
    .rx_valid_i (rx_valid_i),
    .rx_char_i  (rx_char_i),
    .rx_perr_i  (rx_perr_i),
    .rx_ferr_i  (rx_ferr_i),
    .rx_brk_i   (rx_brk_i),
    .data_o     (rx_byte),
    .dr_o       (dr_o),
    .overrun_o  (overrun_o),
    .perr_o     (perr_o),
    .ferr_o     (ferr_o),
    .brk_o      (brk_o)
  );

  uart_dbuf_tx #(.DEPTH(TX_DEPTH)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_en_i   (fifo_en_i),
    .flush_i     (fifo_cfg_wr_i),
    .push_i      (data_wr),
    .wdata_i     (wdata_i[7:0]),
    .tsr_empty_i (tsr_empty_i),
    .tsr_load_o  (tsr_load_o),
    .tsr_data_o  (tsr_data_o),
    .tdrq_o      (tdrq_o)
  );

  // divisor-side accesses must leave both data stores alone
  assert_dlab_iso_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && dlab_i && !rx_valid_i && !tsr_empty_i && !fifo_cfg_wr_i) |=>
      ($stable(dr_o) && $stable(tdrq_o)));
  assert_pad_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[BUS_W-1:8] == '0);
endmodule

// File: tb/uart_dbuf_bench.sv
module uart_dbuf_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 0, rd_i = 0, wr_i = 0, dlab_i = 0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        div_rd_o, div_wr_o;
  logic        fifo_en_i = 0, fifo_cfg_wr_i = 0;
  logic [1:0]  char_len_i = 2'd3;
  logic        lsr_rd_i = 0;
  logic        rx_valid_i = 0;
  logic [7:0]  rx_char_i = '0;
  logic        rx_perr_i = 0, rx_ferr_i = 0, rx_brk_i = 0;
  logic        tsr_empty_i = 0;
  logic        tsr_load_o;
  logic [7:0]  tsr_data_o;
  logic        dr_o, tdrq_o, overrun_o, perr_o, ferr_o, brk_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  uart_dbuf u_uart_dbuf (.*);

  // {char_len, received char, expected byte}
  localparam int NVEC = 9;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 8'hff, 8'h1f}, {2'd1, 8'hff, 8'h3f}, {2'd2, 8'hff, 8'h7f},
    {2'd3, 8'hff, 8'hff}, {2'd0, 8'ha5, 8'h05}, {2'd1, 8'ha5, 8'h25},
    {2'd2, 8'ha5, 8'h25}, {2'd3, 8'ha5, 8'ha5}, {2'd1, 8'hc3, 8'h03}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rx_put(input logic [7:0] c, input logic [1:0] len,
                        input logic p, input logic f, input logic b);
    @(negedge clk_i);
    rx_valid_i = 1; rx_char_i = c; char_len_i = len;
    rx_perr_i = p; rx_ferr_i = f; rx_brk_i = b;
    @(negedge clk_i);
    rx_valid_i = 0; rx_perr_i = 0; rx_ferr_i = 0; rx_brk_i = 0;
  endtask

  task automatic bus_read(input logic dl, output logic [31:0] d, output logic dv);
    @(negedge clk_i);
    sel_i = 1; rd_i = 1; dlab_i = dl;
    #1 d = rdata_o; dv = div_rd_o;
    @(negedge clk_i);
    sel_i = 0; rd_i = 0; dlab_i = 0;
  endtask

  task automatic bus_write(input logic dl, input logic [31:0] d, output logic dv);
    @(negedge clk_i);
    sel_i = 1; wr_i = 1; dlab_i = dl; wdata_i = d;
    #1 dv = div_wr_o;
    @(negedge clk_i);
    sel_i = 0; wr_i = 0; dlab_i = 0; wdata_i = '0;
  endtask

  task automatic set_mode(input logic en);
    @(negedge clk_i);
    fifo_en_i = en; fifo_cfg_wr_i = 1;
    @(negedge clk_i);
    fifo_cfg_wr_i = 0;
  endtask

  task automatic clear_lsr();
    @(negedge clk_i); lsr_rd_i = 1;
    @(negedge clk_i); lsr_rd_i = 0;
  endtask

  // one cycle of shift-register-empty; returns load pulse and byte
  task automatic tsr_pull(output logic ld, output logic [7:0] b);
    @(negedge clk_i);
    tsr_empty_i = 1;
    #1 ld = tsr_load_o; b = tsr_data_o;
    @(negedge clk_i);
    tsr_empty_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        dv, ld;
    logic [7:0]  b;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R11 reset state
    check("R11 dr", dr_o, 0);
    check("R11 tdrq", tdrq_o, 1);
    check("R11 flags", {overrun_o, perr_o, ferr_o, brk_o}, 0);
    bus_read(0, d, dv);
    check("R11 empty read", d, 0);

    // R1/R2 vector walk in non-FIFO mode
    for (int i = 0; i < NVEC; i++) begin
      rx_put(VEC[i][15:8], VEC[i][17:16], 0, 0, 0);
      check("R2 dr set", dr_o, 1);
      bus_read(0, d, dv);
      check("R1 byte", d[7:0], VEC[i][7:0]);
      check("R1 pad zero", d[31:8], 0);
      check("R2 dr clear", dr_o, 0);
    end

    // R3 error flags survive a data read
    rx_put(8'h5a, 2'd3, 1, 0, 1);
    bus_read(0, d, dv);
    check("R3 read data", d, 32'h5a);
    check("R3 flags kept", {overrun_o, perr_o, ferr_o, brk_o}, 4'b0101);
    clear_lsr();
    check("R3 lsr clear", {overrun_o, perr_o, ferr_o, brk_o}, 0);

    // R5 overrun in non-FIFO mode
    rx_put(8'h11, 2'd3, 0, 0, 0);
    rx_put(8'h22, 2'd3, 0, 0, 0);
    check("R5 overrun", overrun_o, 1);
    bus_read(0, d, dv);
    check("R5 data kept", d, 32'h11);
    check("R5 empty after", dr_o, 0);
    clear_lsr();

    // R4 FIFO order and data-ready
    set_mode(1);
    rx_put(8'h01, 2'd3, 0, 0, 0);
    rx_put(8'h02, 2'd3, 0, 0, 0);
    rx_put(8'h03, 2'd3, 0, 0, 0);
    for (int i = 1; i <= 3; i++) begin
      bus_read(0, d, dv);
      check("R4 order", d, 32'(i));
      check("R4 dr", dr_o, (i < 3) ? 1 : 0);
    end

    // R5 overrun in FIFO mode: 16 fit, 17th dropped
    for (int i = 0; i < 17; i++) rx_put(8'(8'h40 + i), 2'd3, 0, 0, 0);
    check("R5 fifo overrun", overrun_o, 1);
    bus_read(0, d, dv);
    check("R5 fifo head kept", d, 32'h40);
    for (int i = 1; i < 16; i++) bus_read(0, d, dv);
    check("R5 last stored", d, 32'h4f);
    check("R4 drained", dr_o, 0);
    clear_lsr();

    // R6/R8 non-FIFO transmit
    set_mode(0);
    bus_write(0, 32'hdead_00ab, dv);
    check("R6 tdrq low", tdrq_o, 0);
    bus_write(0, 32'h0000_00cd, dv);
    tsr_pull(ld, b);
    check("R6 load", ld, 1);
    check("R8 data", b, 8'hab);
    check("R6 tdrq set", tdrq_o, 1);
    tsr_pull(ld, b);
    check("R6 dropped write", ld, 0);

    // R7 FIFO transmit order
    set_mode(1);
    bus_write(0, 32'h0000_0010, dv);
    bus_write(0, 32'h0000_0020, dv);
    bus_write(0, 32'hffff_ff30, dv);
    check("R7 tdrq low", tdrq_o, 0);
    for (int i = 1; i <= 3; i++) begin
      tsr_pull(ld, b);
      check("R7 load", ld, 1);
      check("R7 order", b, 8'(i * 16));
    end
    check("R7 tdrq empty", tdrq_o, 1);

    // R9 divisor-side isolation
    rx_put(8'h77, 2'd3, 0, 0, 0);
    bus_read(1, d, dv);
    check("R9 div_rd", dv, 1);
    check("R9 rdata zero", d, 0);
    check("R9 dr kept", dr_o, 1);
    bus_write(1, 32'h0000_0099, dv);
    check("R9 div_wr", dv, 1);
    check("R9 tdrq kept", tdrq_o, 1);
    bus_read(0, d, dv);
    check("R9 rx intact", d, 32'h77);

    // R10 flush of both stores
    rx_put(8'h55, 2'd3, 0, 0, 0);
    bus_write(0, 32'h0000_0066, dv);
    set_mode(1);
    check("R10 dr", dr_o, 0);
    check("R10 tdrq", tdrq_o, 1);
    tsr_pull(ld, b);
    check("R10 tx emptied", ld, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule